// File: doc/BRIEF.md
# Serial-Character 1-Wire Bus Master

This block runs a 1-Wire bus through a half-duplex, open-drain serial line. It makes each bus slot from one whole serial character: the character goes out, and its own echo comes back over the shared line. Any bus device that pulls the line low during the character changes that echo, so the echo carries the slot's result. The serializer sits beside the block and works at character level. The block tells it which character to send and which of two bit rates to use, and it takes back each received character together with any framing, noise, overrun or line-break indication.

A command can contain a reset with presence detect, a write of N bytes, and a read of M bytes. The block always runs these parts in that order, and any part may be left out. Write bytes come in on a valid/ready byte stream and read bytes go out on another. Each command ends with a one-cycle done pulse carrying a 2-bit status. A programmable cycle count bounds how long the block waits for each echo, so a line held low cannot hang the block.

Top module: `ow_uart_master`

## Requirements
- R1: A reset slot transmits the character 0xF0 with `tx_slow` high (low bit rate).
- R2: After a reset echo that differs from 0xF0, the command goes on to its next part. An echo of exactly 0xF0 ends the command with status 1 (no device), and no further character is sent.
- R3: Write slots run with `tx_slow` low and use one character per bit: 0xFF for a 1 and 0x00 for a 0. Bits go least-significant first. One byte is taken from the write stream (`wr_valid`/`wr_ready`) for every 8 slots, in stream order.
- R4: Every read slot sends 0xFF. A bit reads as 1 only when its echo is exactly 0xFF; any other echo reads as 0. Bits are assembled least-significant first. Each finished byte is offered on `rd_valid`/`rd_data` and held unchanged until `rd_ready` accepts it.
- R5: No new character is sent until the previous one has received its echo, a line fault, or a timeout.
- R6: The parts of a command run in the order reset, write, read. A part with zero length is skipped. A command with no reset and both lengths zero completes with status 0 and sends no character.
- R7: A line fault (`rx_error` or `rx_break`) that arrives while an echo is awaited ends the command with status 2 in the next cycle, and no further character is sent. A fault takes priority over an echo that arrives in the same cycle.
- R8: Suppose a character is sent in cycle t with `timeout_limit` = L. If no echo or fault arrives in cycles t+1 through t+L+1, done rises in cycle t+L+2 with status 3. An echo that arrives in cycle t+L+1 is still accepted.
- R9: `done` is high for exactly one cycle per command and carries `status`: 0 success, 1 no device, 2 line fault, 3 timeout. `cmd_ready` is high only while the block is idle.
- R10: While reset is held, `cmd_ready` is high and `tx_valid`, `done`, `wr_ready` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_do_reset | input | 1 | Command starts with a reset/presence slot |
| cmd_wr_bytes | input | LEN_W | Number of bytes to write |
| cmd_rd_bytes | input | LEN_W | Number of bytes to read |
| timeout_limit | input | TMO_W | Echo wait bound in cycles |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream byte accepted |
| tx_data | output | 8 | Character for the serializer |
| tx_valid | output | 1 | Send strobe, one cycle |
| tx_slow | output | 1 | 1 selects the reset bit rate, 0 the slot bit rate |
| rx_data | input | 8 | Received echo character |
| rx_valid | input | 1 | Echo character present |
| rx_error | input | 1 | Framing, noise or overrun seen |
| rx_break | input | 1 | Line break seen |
| done | output | 1 | Command finished, one cycle |
| status | output | 2 | Completion code, valid with done |

## Verification
The bench builds the block with LEN_W = 4 and TMO_W = 8, and drives `timeout_limit` at 12. The echo window is short, so the exact timeout cycle and an echo arriving in the last accepted cycle can both be reached within a few dozen clocks. The 4-bit length still allows multi-byte writes and reads with back-pressure on the read stream. A behavioural device model in the bench varies the presence echo, the non-0xFF read echoes, the echo delay, and the character at which it injects a fault, a break or silence.

// File: rtl/ow_pkg.sv
package ow_pkg;

  localparam int unsigned SLOT_BITS = 8;

  localparam logic [7:0] PULSE_RESET = 8'hF0;
  localparam logic [7:0] SLOT_HIGH   = 8'hFF;
  localparam logic [7:0] SLOT_LOW    = 8'h00;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_NODEV = 2'd1,
    ST_LINE  = 2'd2,
    ST_TMO   = 2'd3
  } ow_status_e;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ECHO   = 2'd1,
    EV_FAULT  = 2'd2,
    EV_EXPIRE = 2'd3
  } ow_event_e;

  // Character that encodes one written bit.
  function automatic logic [7:0] slot_char(input logic b);
    return b ? SLOT_HIGH : SLOT_LOW;
  endfunction

  // A read slot yields 1 only when nobody pulled the line.
  function automatic logic sampled_bit(input logic [7:0] echo);
    return echo == SLOT_HIGH;
  endfunction

  // Any change to the reset character means a device answered.
  function automatic logic device_answered(input logic [7:0] echo);
    return echo != PULSE_RESET;
  endfunction

endpackage

// File: rtl/ow_echo_timer.sv
module ow_echo_timer #(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             waiting,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (arm)                 cnt <= limit;
    else if (waiting && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expired = waiting && (cnt == '0);
endmodule

// File: rtl/ow_echo_decode.sv
module ow_echo_decode
  import ow_pkg::*;
(
  input  logic      waiting,
  input  logic      rx_valid,
  input  logic      rx_error,
  input  logic      rx_break,
  input  logic      expired,
  output ow_event_e ev
);
  always_comb begin
    if (!waiting)                 ev = EV_NONE;
    else if (rx_error || rx_break) ev = EV_FAULT;
    else if (rx_valid)            ev = EV_ECHO;
    else if (expired)             ev = EV_EXPIRE;
    else                          ev = EV_NONE;
  end
endmodule

// File: rtl/ow_bit_shifter.sv
module ow_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic         cur_bit,
  output logic [W-1:0] word,
  output logic         last
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= load_val;
      idx <= '0;
    end else if (shift) begin
      sr  <= {shift_in, sr[W-1:1]};
      idx <= last ? '0 : idx + 1'b1;
    end
  end

  assign cur_bit = sr[0];
  assign word    = sr;
  assign last    = (idx == IW'(W - 1));
endmodule

// File: rtl/ow_uart_master.sv
module ow_uart_master
  import ow_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_do_reset,
  input  logic [LEN_W-1:0] cmd_wr_bytes,
  input  logic [LEN_W-1:0] cmd_rd_bytes,
  input  logic [TMO_W-1:0] timeout_limit,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_slow,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             rx_error,
  input  logic             rx_break,
  output logic             done,
  output logic [1:0]       status
);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_TX, S_RST_WT, S_WR_GET, S_WR_TX, S_WR_WT,
    S_RD_TX, S_RD_WT, S_RD_PUT, S_FIN
  } seq_e;

  seq_e             state, nxt;
  ow_status_e       stat, nstat;
  logic [LEN_W-1:0] wr_left, rd_left;

  // Internal events brought out as named wires.
  logic      waiting;
  logic      expired;
  ow_event_e ev;
  logic      sh_load, sh_shift, sh_bit, sh_last;
  logic [SLOT_BITS-1:0] sh_load_val, sh_word;
  logic      latch, wr_dec, rd_dec;

  assign waiting = (state == S_RST_WT) || (state == S_WR_WT) || (state == S_RD_WT);

  ow_echo_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (tx_valid),
    .waiting (waiting),
    .limit   (timeout_limit),
    .expired (expired)
  );

  ow_echo_decode u_decode (
    .waiting  (waiting),
    .rx_valid (rx_valid),
    .rx_error (rx_error),
    .rx_break (rx_break),
    .expired  (expired),
    .ev       (ev)
  );

  ow_bit_shifter #(.W(SLOT_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (sh_load_val),
    .shift    (sh_shift),
    .shift_in (sampled_bit(rx_data)),
    .cur_bit  (sh_bit),
    .word     (sh_word),
    .last     (sh_last)
  );

  always_comb begin
    nxt         = state;
    nstat       = stat;
    sh_load     = 1'b0;
    sh_load_val = '0;
    sh_shift    = 1'b0;
    latch       = 1'b0;
    wr_dec      = 1'b0;
    rd_dec      = 1'b0;
    if (waiting && ev == EV_FAULT) begin
      nxt   = S_FIN;
      nstat = ST_LINE;
    end else if (waiting && ev == EV_EXPIRE) begin
      nxt   = S_FIN;
      nstat = ST_TMO;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          latch = 1'b1;
          nstat = ST_OK;
          if (cmd_do_reset)           nxt = S_RST_TX;
          else if (cmd_wr_bytes != 0) nxt = S_WR_GET;
          else if (cmd_rd_bytes != 0) begin nxt = S_RD_TX; sh_load = 1'b1; end
          else                        nxt = S_FIN;
        end
        S_RST_TX: nxt = S_RST_WT;
        S_RST_WT: if (ev == EV_ECHO) begin
          if (!device_answered(rx_data)) begin
            nxt   = S_FIN;
            nstat = ST_NODEV;
          end else if (wr_left != 0) nxt = S_WR_GET;
          else if (rd_left != 0) begin nxt = S_RD_TX; sh_load = 1'b1; end
          else nxt = S_FIN;
        end
        S_WR_GET: if (wr_valid) begin
          sh_load     = 1'b1;
          sh_load_val = wr_data;
          nxt         = S_WR_TX;
        end
        S_WR_TX: nxt = S_WR_WT;
        S_WR_WT: if (ev == EV_ECHO) begin
          sh_shift = 1'b1;
          if (sh_last) begin
            wr_dec = 1'b1;
            if (wr_left == 1) begin
              if (rd_left != 0) begin nxt = S_RD_TX; sh_load = 1'b1; end
              else nxt = S_FIN;
            end else nxt = S_WR_GET;
          end else nxt = S_WR_TX;
        end
        S_RD_TX: nxt = S_RD_WT;
        S_RD_WT: if (ev == EV_ECHO) begin
          sh_shift = 1'b1;
          nxt      = sh_last ? S_RD_PUT : S_RD_TX;
        end
        S_RD_PUT: if (rd_ready) begin
          rd_dec = 1'b1;
          nxt    = (rd_left == 1) ? S_FIN : S_RD_TX;
        end
        S_FIN:   nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stat    <= ST_OK;
      wr_left <= '0;
      rd_left <= '0;
    end else begin
      state <= nxt;
      stat  <= nstat;
      if (latch) begin
        wr_left <= cmd_wr_bytes;
        rd_left <= cmd_rd_bytes;
      end else begin
        if (wr_dec) wr_left <= wr_left - 1'b1;
        if (rd_dec) rd_left <= rd_left - 1'b1;
      end
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign wr_ready  = (state == S_WR_GET);
  assign rd_valid  = (state == S_RD_PUT);
  assign rd_data   = sh_word;
  assign tx_valid  = (state == S_RST_TX) || (state == S_WR_TX) || (state == S_RD_TX);
  assign tx_slow   = (state == S_RST_TX) || (state == S_RST_WT);
  assign tx_data   = (state == S_RST_TX) ? PULSE_RESET :
                     (state == S_WR_TX)  ? slot_char(sh_bit) : SLOT_HIGH;
  assign done      = (state == S_FIN);
  assign status    = stat;

endmodule

// File: rtl/ow_uart_master_chk.sv
module ow_uart_master_chk #(
  parameter int TMO_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic [TMO_W-1:0] timeout_limit,
  input logic [7:0]       rd_data,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       tx_data,
  input logic             tx_valid,
  input logic             tx_slow,
  input logic             rx_valid,
  input logic             rx_error,
  input logic             rx_break,
  input logic             done,
  input logic [1:0]       status
);
  logic             outstanding;
  logic [TMO_W+1:0] since_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      since_tx    <= '0;
    end else begin
      if (tx_valid) outstanding <= 1'b1;
      else if (rx_valid || rx_error || rx_break || done) outstanding <= 1'b0;
      if (tx_valid) since_tx <= 1;
      else if (since_tx != '1) since_tx <= since_tx + 1'b1;
    end
  end

  // R1
  reset_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_slow |-> tx_data == 8'hF0);

  // R3
  slot_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_slow |-> (tx_data == 8'hFF || tx_data == 8'h00));

  // R5
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !outstanding);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R7
  fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_error || rx_break) && outstanding && !done |=> done && status == 2'd2);

  // R8
  timeout_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 2'd3 |-> since_tx == ({2'b00, timeout_limit} + 2));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready);

endmodule

bind ow_uart_master ow_uart_master_chk #(.TMO_W(TMO_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .timeout_limit (timeout_limit),
  .rd_data       (rd_data),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .tx_data       (tx_data),
  .tx_valid      (tx_valid),
  .tx_slow       (tx_slow),
  .rx_valid      (rx_valid),
  .rx_error      (rx_error),
  .rx_break      (rx_break),
  .done          (done),
  .status        (status)
);

// File: tb/ow_uart_master_test.sv
module ow_uart_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 4;
  localparam int TMO_W = 8;
  localparam int LIM   = 12;

  logic clk, rst_n;
  logic cmd_valid, cmd_ready, cmd_do_reset;
  logic [LEN_W-1:0] cmd_wr_bytes, cmd_rd_bytes;
  logic [TMO_W-1:0] timeout_limit;
  logic [7:0] wr_data, rd_data, tx_data, rx_data;
  logic wr_valid, wr_ready, rd_valid, rd_ready, tx_valid, tx_slow;
  logic rx_valid, rx_error, rx_break, done;
  logic [1:0] status;

  ow_uart_master #(.LEN_W(LEN_W), .TMO_W(TMO_W)) uut (.*);

  int errors = 0, checks = 0;
  int cyc = 0, last_tx = 0, done_cnt = 0;
  logic [8:0] exp_tx[$];
  logic [7:0] exp_rd[$], wr_q[$], wbytes[$], sbytes[$];
  logic [1:0] exp_st[$];
  bit slave_bits[$];
  bit wr_took = 0, rd_bp = 0, hold_v = 0;
  logic [7:0] hold_d;
  // device model
  int char_idx, fast_seen, rsp_wr_slots, fault_at, fault_kind, rsp_delay, rsp_cnt = 0, zi = 0;
  int pend_kind;
  logic [7:0] rsp_reset_echo, pend_echo;

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] zero_echo();
    logic [7:0] v;
    v = (zi % 3 == 0) ? 8'hFE : (zi % 3 == 1) ? 8'h7F : 8'h00;
    zi++;
    return v;
  endfunction

  // Per-cycle environment, all at the falling edge.
  initial begin
    rx_valid = 0; rx_error = 0; rx_break = 0; rx_data = 0;
    wr_valid = 0; wr_data = 0; rd_ready = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (wr_took) void'(wr_q.pop_front());
      wr_valid = wr_q.size() > 0;
      wr_data  = wr_valid ? wr_q[0] : 8'h00;
      wr_took  = wr_valid && wr_ready;
      rx_valid = 0; rx_error = 0; rx_break = 0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          if (pend_kind == 0) begin rx_valid = 1; rx_data = pend_echo; end
          else if (pend_kind == 2) rx_error = 1;
          else if (pend_kind == 3) rx_break = 1;
        end
      end
      if (tx_valid) begin
        if (exp_tx.size() == 0) chk(0, "R5", "unexpected character", tx_data, 0);
        else begin
          logic [8:0] e;
          e = exp_tx.pop_front();
          chk({tx_slow, tx_data} == e, e[8] ? "R1" : "R3/R4", "slot character",
              {tx_slow, tx_data}, e);
        end
        last_tx = cyc;
        if (char_idx == fault_at) begin
          pend_kind = fault_kind;
        end else begin
          pend_kind = 0;
          if (tx_slow) pend_echo = rsp_reset_echo;
          else if (fast_seen < rsp_wr_slots) begin pend_echo = tx_data; fast_seen++; end
          else begin
            bit b;
            b = (slave_bits.size() > 0) ? slave_bits.pop_front() : 1'b1;
            fast_seen++;
            pend_echo = b ? 8'hFF : zero_echo();
          end
        end
        char_idx++;
        rsp_cnt = (pend_kind == 1) ? 0 : rsp_delay;
      end
      if (done) begin
        logic [1:0] s;
        s = (exp_st.size() > 0) ? exp_st.pop_front() : 2'bxx;
        chk(status === s, "R9", "done status", status, s);
        chk(exp_tx.size() == 0, "R6", "characters left unsent", exp_tx.size(), 0);
        if (s == 2'd3) chk(cyc - last_tx == LIM + 2, "R8", "timeout cycle", cyc - last_tx, LIM + 2);
        done_cnt++;
      end
      if (hold_v) chk(rd_valid && rd_data == hold_d, "R4", "held read byte", rd_data, hold_d);
      rd_ready = rd_bp ? (cyc % 3 == 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        logic [7:0] r;
        r = (exp_rd.size() > 0) ? exp_rd.pop_front() : 8'hxx;
        chk(rd_data === r, "R4", "read byte", rd_data, r);
      end
      hold_v = rd_valid && !rd_ready;
      hold_d = rd_data;
    end
  end

  // wbytes/sbytes prefilled; kind: 1 silent, 2 error, 3 break
  task automatic run_cmd(bit do_rst, int rd_n, logic [7:0] recho, int f_at, int f_kind,
                         int dly, bit bp);
    int idx, stop, target;
    logic [1:0] st;
    @(posedge clk);
    char_idx = 0; fast_seen = 0; rsp_wr_slots = 8 * wbytes.size();
    fault_at = f_at; fault_kind = f_kind; rsp_delay = dly; rsp_reset_echo = recho;
    rd_bp = bp;
    foreach (sbytes[j]) for (int k = 0; k < 8; k++) slave_bits.push_back(sbytes[j][k]);
    foreach (wbytes[j]) wr_q.push_back(wbytes[j]);
    idx = 0; stop = 0; st = 2'd0;
    if (do_rst) begin
      exp_tx.push_back({1'b1, 8'hF0});
      if (idx == f_at) begin st = (f_kind == 1) ? 2'd3 : 2'd2; stop = 1; end
      else if (recho == 8'hF0) begin st = 2'd1; stop = 1; end
      idx++;
    end
    foreach (wbytes[j]) for (int k = 0; k < 8; k++) if (!stop) begin
      exp_tx.push_back({1'b0, wbytes[j][k] ? 8'hFF : 8'h00});
      if (idx == f_at) begin st = (f_kind == 1) ? 2'd3 : 2'd2; stop = 1; end
      idx++;
    end
    for (int j = 0; j < rd_n; j++) begin
      for (int k = 0; k < 8; k++) if (!stop) begin
        exp_tx.push_back({1'b0, 8'hFF});
        if (idx == f_at) begin st = (f_kind == 1) ? 2'd3 : 2'd2; stop = 1; end
        idx++;
      end
      if (!stop) exp_rd.push_back(sbytes[j]);
    end
    exp_st.push_back(st);
    target = done_cnt + 1;
    @(negedge clk);
    cmd_valid = 1; cmd_do_reset = do_rst;
    cmd_wr_bytes = LEN_W'(wbytes.size()); cmd_rd_bytes = LEN_W'(rd_n);
    @(negedge clk);
    cmd_valid = 0;
    while (done_cnt < target) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_rd.size() == 0, "R4", "read bytes missing", exp_rd.size(), 0);
    @(posedge clk);
    wr_q.delete(); wbytes.delete(); sbytes.delete(); slave_bits.delete(); exp_rd.delete();
    rsp_cnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_do_reset = 0; cmd_wr_bytes = 0; cmd_rd_bytes = 0;
    timeout_limit = TMO_W'(LIM); fault_at = -1; fault_kind = 0; rsp_delay = 3;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cmd_ready == 1, "R10", "cmd_ready in reset", cmd_ready, 1);
    chk(tx_valid == 0 && done == 0, "R10", "tx/done in reset", {tx_valid, done}, 0);
    chk(wr_ready == 0 && rd_valid == 0, "R10", "streams in reset", {wr_ready, rd_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 R2: device present
    run_cmd(1, 0, 8'hE0, -1, 0, 3, 0);
    // R2: no device, nothing after reset
    wbytes.push_back(8'h55); sbytes.push_back(8'h11);
    run_cmd(1, 1, 8'hF0, -1, 0, 3, 0);
    // R3: two-byte write, LSB first
    wbytes.push_back(8'hA5); wbytes.push_back(8'h3C);
    run_cmd(0, 0, 8'hE0, -1, 0, 2, 0);
    // R4: two-byte read with back-pressure
    sbytes.push_back(8'h5A); sbytes.push_back(8'hC3);
    run_cmd(0, 2, 8'hE0, -1, 0, 4, 1);
    // R6: full command, presence echo 0x00
    wbytes.push_back(8'h96); sbytes.push_back(8'hE7); sbytes.push_back(8'h18);
    run_cmd(1, 2, 8'h00, -1, 0, 1, 1);
    // R4: all-zero and all-one bytes
    sbytes.push_back(8'h00); sbytes.push_back(8'hFF);
    run_cmd(0, 2, 8'hE0, -1, 0, 2, 0);
    // R7: framing error during write
    wbytes.push_back(8'hF0); wbytes.push_back(8'h0F); sbytes.push_back(8'h33);
    run_cmd(0, 1, 8'hE0, 5, 2, 3, 0);
    // R7: break during the second read byte
    sbytes.push_back(8'h81); sbytes.push_back(8'h42);
    run_cmd(0, 2, 8'hE0, 11, 3, 3, 0);
    // R7: error on the reset character
    wbytes.push_back(8'h01);
    run_cmd(1, 0, 8'hE0, 0, 2, 2, 0);
    // R8: silent device during read
    wbytes.push_back(8'h77); sbytes.push_back(8'h99);
    run_cmd(0, 1, 8'hE0, 9, 1, 3, 0);
    // R8: silent device at reset
    run_cmd(1, 0, 8'hE0, 0, 1, 3, 0);
    // R8: echo in the last accepted cycle
    run_cmd(1, 0, 8'hE0, -1, 0, LIM + 1, 0);
    // R6: empty command
    run_cmd(0, 0, 8'hE0, -1, 0, 3, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule